// File: doc/BRIEF.md
# Dual-SRAM Shared-Bus Access Sequencer

This block runs on a fast clock, several times the system dot clock, and controls one memory bus with multiplexed address and data. Two SRAMs sit on that bus. The small, fast one holds the page-mapping table. The large one holds the data. Each time phi2 goes high, a cycle counter restarts. The sequencer then walks a fixed schedule of fast cycles. First it reads the mapping entry for the current task and the CPU's 4 kB page. Next it leaves the bus undriven for one turnaround cycle. Last it performs one of two accesses: a CPU access to a mapping-table slot, or a data access whose address is built from the latched mapping entry.

A decoder outside this block decides whether the current CPU access targets a mapping slot and presents that as one input bit. The sequencer does not decide translation policy or the register map. It only times the chip selects, the output enable, the write strobe and the shared address. It also holds the most recent mapping entry it has read. All strobes are active high.

Top module: `shbus_seq`

## Requirements
- R1: While reset is held and after reset is released with phi2 low, map_cs, data_cs, sram_oe, sram_we and bus_drive are 0 and map_value is 0.
- R2: The counter takes the value 0 in the first fast cycle after a clock edge that samples phi2 high when the previous sample was low. In counts 0 and 1, nothing is selected or enabled.
- R3: In counts 2 and 3, map_cs and sram_oe are 1 and data_cs, sram_we and bus_drive are 0. sram_addr carries task_id in bits 11:4 and cpu_addr[15:12] in bits 3:0, with the upper bits 0.
- R4: map_value takes sram_rdata only at the clock edge that ends count 3. At every other edge it keeps its value.
- R5: In count 4, no chip select, no output enable, no write strobe and no bus drive is active.
- R6: From count 5 on, when cpu_map_slot is 1, map_cs is 1. sram_addr carries task_id in bits 11:4 and cpu_addr[3:0] in bits 3:0.
- R7: From count 5 on, when cpu_map_slot is 0 and map_value is non-zero, data_cs is 1. sram_addr carries map_value[6:0] in bits 18:12 and cpu_addr[11:0] in bits 11:0.
- R8: From count 5 on, when cpu_map_slot is 0 and map_value is 0, no chip select and no strobe is active.
- R9: During the access phase, sram_oe follows cpu_rnw=1. For cpu_rnw=0, bus_drive is 1 and bus_wdata equals cpu_wdata from count 5, and sram_we is 1 only from count 6.
- R10: In any cycle where phi2 is 0, all selects, enables and bus_drive are 0 in that same cycle, with no wait for a clock edge.
- R11: When phi2 stays high past the counter's maximum, the counter holds at that maximum. The lookup and turnaround strobes do not come back, and the access phase continues.
- R12: map_cs and data_cs are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phi2 | input | 1 | System phase-2 clock, sampled on clk |
| cpu_addr | input | 16 | CPU address |
| cpu_rnw | input | 1 | 1 = CPU read, 0 = CPU write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_map_slot | input | 1 | Access targets a mapping-table slot |
| task_id | input | 8 | Current mapping set |
| sram_rdata | input | 8 | Data returned on the shared bus |
| map_cs | output | 1 | Mapping SRAM select |
| data_cs | output | 1 | Data SRAM select |
| sram_oe | output | 1 | Shared output enable |
| sram_we | output | 1 | Shared write strobe |
| sram_addr | output | 19 | Shared address |
| bus_drive | output | 1 | Block drives bus_wdata onto the bus |
| bus_wdata | output | 8 | Write data for the bus |
| map_value | output | 8 | Latched mapping entry |

## Verification
All strobes are combinational, decoded from the registered count and the live phi2. The output value for count k is therefore valid in the fast cycle that follows the k-th clock edge after the rise edge. The scoreboard expects one item per cycle and samples it 1 ns after each rising edge. The latched mapping entry is expected to change from count 4 on. The bench drives different junk data in counts 2 and 4, so a capture one cycle early or late is caught. The drop of phi2 is checked 1 ns after it happens, before any clock edge, to show that the strobes turn off in that same cycle.

// File: rtl/shbus_pkg.sv
package shbus_pkg;

    // fixed schedule inside the phi2-high window (fast-clock counts)
    localparam int LOOK_FIRST = 2;
    localparam int LOOK_LAST  = 3;
    localparam int TURN_CNT   = 4;
    localparam int ACC_FIRST  = 5;
    localparam int WE_FIRST   = 6;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_TABLE = 2'd1,
        ACC_DATA  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic map_cs;
        logic data_cs;
        logic oe;
        logic we;
        logic drive;
    } strobe_t;

endpackage

// File: rtl/shbus_phase_ctr.sv
module shbus_phase_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phi2,
    output logic             active,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             phi2_seen;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.phi2_seen = phi2;
        if (!phi2) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (!st_q.phi2_seen) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign cnt    = st_q.cnt;

    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && !st_q.phi2_seen) |=> (active && cnt == '0)); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && active && cnt == CNT_MAX) |=> (!phi2 || cnt == CNT_MAX)); // R11

endmodule

// File: rtl/shbus_map_latch.sv
module shbus_map_latch #(
    parameter int MAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [MAP_W-1:0] rdata,
    output logic [MAP_W-1:0] value
);
    logic [MAP_W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (capture) value_d = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    assign value = value_q;

endmodule

// File: rtl/shbus_strobe_gen.sv
module shbus_strobe_gen
    import shbus_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int ADDR_W  = 16,
    parameter int SLOT_W  = 4,
    parameter int TASK_W  = 8,
    parameter int MAP_W   = 8,
    parameter int DATA_W  = 8,
    parameter int DATA_AW = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phi2,
    input  logic               active,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rnw,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_map_slot,
    input  logic [TASK_W-1:0]  task_id,
    input  logic [MAP_W-1:0]   map_value,
    output strobe_t            strobe,
    output logic [DATA_AW-1:0] sram_addr,
    output logic [DATA_W-1:0]  bus_wdata
);
    localparam int PAGE_W  = ADDR_W - SLOT_W;
    localparam int FRAME_W = DATA_AW - PAGE_W;
    localparam int MAP_AW  = TASK_W + SLOT_W;

    logic      live, in_look, in_turn, in_acc, we_ok;
    acc_kind_e kind;

    always_comb begin
        live    = active && phi2;
        in_look = live && (cnt == CNT_W'(LOOK_FIRST) || cnt == CNT_W'(LOOK_LAST));
        in_turn = live && (cnt == CNT_W'(TURN_CNT));
        in_acc  = live && (cnt >= CNT_W'(ACC_FIRST));
        we_ok   = live && (cnt >= CNT_W'(WE_FIRST));

        kind = ACC_NONE;
        if (in_acc) begin
            if (cpu_map_slot)          kind = ACC_TABLE;
            else if (map_value != '0)  kind = ACC_DATA;
        end

        strobe    = '0;
        sram_addr = '0;
        bus_wdata = '0;
        if (in_look) begin
            strobe.map_cs = 1'b1;
            strobe.oe     = 1'b1;
            sram_addr     = DATA_AW'({task_id, cpu_addr[ADDR_W-1 -: SLOT_W]});
        end else if (kind != ACC_NONE) begin
            strobe.map_cs  = (kind == ACC_TABLE);
            strobe.data_cs = (kind == ACC_DATA);
            strobe.oe      = cpu_rnw;
            strobe.drive   = !cpu_rnw;
            strobe.we      = !cpu_rnw && we_ok;
            if (!cpu_rnw) bus_wdata = cpu_wdata;
            if (kind == ACC_TABLE)
                sram_addr = DATA_AW'({task_id, cpu_addr[SLOT_W-1:0]});
            else
                sram_addr = {map_value[FRAME_W-1:0], cpu_addr[PAGE_W-1:0]};
        end
    end

    AST_LOOKUP_READS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && active && (cnt == CNT_W'(LOOK_FIRST) || cnt == CNT_W'(LOOK_LAST)))
        |-> (strobe.map_cs && strobe.oe && !strobe.data_cs && !strobe.we && !strobe.drive)); // R3

    AST_TURNAROUND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_turn |-> (strobe == '0)); // R5

    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.we |-> (cnt >= CNT_W'(WE_FIRST) && strobe.drive)); // R9

    AST_PHI2_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> (strobe == '0)); // R10

    AST_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe.map_cs && strobe.data_cs)); // R12

    AST_MAP_ADDR_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.map_cs |-> (sram_addr >> MAP_AW) == '0); // R6

endmodule

// File: rtl/shbus_seq.sv
module shbus_seq
    import shbus_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int ADDR_W  = 16,
    parameter int SLOT_W  = 4,
    parameter int TASK_W  = 8,
    parameter int MAP_W   = 8,
    parameter int DATA_W  = 8,
    parameter int DATA_AW = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phi2,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rnw,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_map_slot,
    input  logic [TASK_W-1:0]  task_id,
    input  logic [MAP_W-1:0]   sram_rdata,
    output logic               map_cs,
    output logic               data_cs,
    output logic               sram_oe,
    output logic               sram_we,
    output logic [DATA_AW-1:0] sram_addr,
    output logic               bus_drive,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic [MAP_W-1:0]   map_value
);
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             capture;
    strobe_t          strobe;

    shbus_phase_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .active(active), .cnt(cnt)
    );

    assign capture = phi2 && active && (cnt == CNT_W'(LOOK_LAST));

    shbus_map_latch #(.MAP_W(MAP_W)) i_latch (
        .clk(clk), .rst_n(rst_n), .capture(capture), .rdata(sram_rdata), .value(map_value)
    );

    shbus_strobe_gen #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .TASK_W(TASK_W),
        .MAP_W(MAP_W), .DATA_W(DATA_W), .DATA_AW(DATA_AW)
    ) i_strobe (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .active(active), .cnt(cnt),
        .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw), .cpu_wdata(cpu_wdata),
        .cpu_map_slot(cpu_map_slot), .task_id(task_id), .map_value(map_value),
        .strobe(strobe), .sram_addr(sram_addr), .bus_wdata(bus_wdata)
    );

    assign map_cs    = strobe.map_cs;
    assign data_cs   = strobe.data_cs;
    assign sram_oe   = strobe.oe;
    assign sram_we   = strobe.we;
    assign bus_drive = strobe.drive;

    AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi2 && active && cnt == CNT_W'(LOOK_LAST)) |=> $stable(map_value)); // R4

    AST_DATA_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        data_cs |-> (map_value != '0 && !cpu_map_slot)); // R7

endmodule

// File: tb/test_shbus_seq.sv
module test_shbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_map_slot = 1'b0;
    logic [7:0]  task_id = '0;
    logic [7:0]  sram_rdata = '0;
    logic        map_cs, data_cs, sram_oe, sram_we, bus_drive;
    logic [18:0] sram_addr;
    logic [7:0]  bus_wdata, map_value;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] cur_mv = '0;

    typedef struct {
        logic        map_cs, data_cs, oe, we, drive, chk_addr;
        logic [18:0] addr;
        logic [7:0]  wdata, mv;
        int          req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    shbus_seq i_shbus_seq (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
        .cpu_wdata(cpu_wdata), .cpu_map_slot(cpu_map_slot), .task_id(task_id),
        .sram_rdata(sram_rdata), .map_cs(map_cs), .data_cs(data_cs), .sram_oe(sram_oe),
        .sram_we(sram_we), .sram_addr(sram_addr), .bus_drive(bus_drive),
        .bus_wdata(bus_wdata), .map_value(map_value)
    );

    task automatic check_idle(input int req, input logic [7:0] mv);
        n_vec++;
        if (map_cs || data_cs || sram_oe || sram_we || bus_drive || map_value != mv) begin
            n_bad++;
            $display("FAIL R%0d idle: cs=%b%b oe=%b we=%b drv=%b mv=%h, expected 00000 mv=%h",
                     req, map_cs, data_cs, sram_oe, sram_we, bus_drive, map_value, mv);
        end
    endtask

    // monitor: one expected item per fast cycle, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (map_value != e.mv) begin
                n_bad++;  // R4 capture timing
                $display("FAIL R4 map_value=%h expected %h", map_value, e.mv);
            end else if (map_cs != e.map_cs || data_cs != e.data_cs || sram_oe != e.oe ||
                         sram_we != e.we || bus_drive != e.drive ||   // R12 via both cs bits
                         (e.chk_addr && sram_addr != e.addr) ||
                         (e.drive && bus_wdata != e.wdata)) begin
                n_bad++;
                $display("FAIL R%0d cs=%b%b oe=%b we=%b drv=%b addr=%h wd=%h, expected cs=%b%b oe=%b we=%b drv=%b addr=%h wd=%h",
                         e.req, map_cs, data_cs, sram_oe, sram_we, bus_drive, sram_addr, bus_wdata,
                         e.map_cs, e.data_cs, e.oe, e.we, e.drive, e.addr, e.wdata);
            end
        end
    end

    // driver: one phi2-high window of len fast cycles, entry v returned in count 3
    task automatic run_access(input logic [7:0] tsk, input logic [15:0] a, input logic rnw,
                              input logic [7:0] wd, input logic slot, input logic [7:0] v,
                              input int len);
        logic [7:0] old_mv;
        old_mv = cur_mv;
        phi2 = 1'b1; task_id = tsk; cpu_addr = a; cpu_rnw = rnw;
        cpu_wdata = wd; cpu_map_slot = slot; sram_rdata = ~v;
        for (int k = 0; k < len; k++) begin
            exp_t e;
            e = '{default: '0};
            e.mv = (k >= 4) ? v : old_mv;
            if (k < 2) begin
                e.req = 2;                                     // R2
            end else if (k < 4) begin
                e.req = 3; e.map_cs = 1; e.oe = 1; e.chk_addr = 1;  // R3
                e.addr = {7'd0, tsk, a[15:12]};
            end else if (k == 4) begin
                e.req = 5;                                     // R5
            end else begin
                if (slot) begin
                    e.req = 6; e.map_cs = 1; e.chk_addr = 1;   // R6
                    e.addr = {7'd0, tsk, a[3:0]};
                end else if (v != 0) begin
                    e.req = 7; e.data_cs = 1; e.chk_addr = 1;  // R7
                    e.addr = {v[6:0], a[11:0]};
                end else begin
                    e.req = 8;                                 // R8
                end
                if (e.map_cs || e.data_cs) begin
                    e.oe = rnw; e.drive = !rnw; e.we = !rnw && (k >= 6); e.wdata = wd;
                    if (!rnw) e.req = 9;                       // R9
                end
                if (k >= 63) e.req = 11;                       // R11 past the counter maximum
            end
            sb.push_back(e);
        end
        begin
            exp_t e;
            e = '{default: '0};
            e.mv = v; e.req = 10;
            sb.push_back(e);
        end
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            sram_rdata = (k == 3) ? v : ~v;  // junk in counts 2 and 4
        end
        phi2 = 1'b0;
        #1;
        check_idle(10, v);  // R10: off within the same cycle
        cur_mv = v;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle(1, 8'h00);  // R1 during reset
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle(1, 8'h00);  // R1 after release
        run_access(8'h03, 16'hC123, 1'b1, 8'h00, 1'b0, 8'h05, 8);   // R7 read
        run_access(8'h7E, 16'h4ABC, 1'b0, 8'h5A, 1'b0, 8'h81, 8);   // R7 R9 write, frame truncated
        run_access(8'h11, 16'h9F00, 1'b1, 8'h00, 1'b0, 8'h00, 8);   // R8 read, no entry
        run_access(8'h22, 16'hDE07, 1'b1, 8'h00, 1'b1, 8'h00, 8);   // R6 table read
        run_access(8'hF0, 16'h200C, 1'b0, 8'h3C, 1'b1, 8'h10, 8);   // R6 R9 table write
        run_access(8'h04, 16'h1FFF, 1'b0, 8'h99, 1'b0, 8'h00, 7);   // R8 write, no strobe
        run_access(8'h5A, 16'hE456, 1'b0, 8'hC3, 1'b0, 8'h2F, 80);  // R11 long window
        run_access(8'h00, 16'h3001, 1'b1, 8'h00, 1'b0, 8'h40, 6);   // R2 R3 back to back
        repeat (4) @(negedge clk);
        check_idle(10, cur_mv);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule